// File: doc/BRIEF.md
# Host Memory Access Port

This block gives an external host direct access to the on-chip program memory (24-bit words) and data memory (16-bit words) over a 16-bit bus that carries both address and data. The host first loads a start location: it raises an address strobe, drives the location and a memory-select bit, then lowers the strobe. After that it moves words with a select strobe combined with a read or a write strobe. The port steps the location by one after each completed word, so a block of consecutive words needs the address only once.

All host strobes cross into the core clock domain through multi-flop synchronisers. For each host access the port issues one request on a simple single-cycle internal memory interface, with read data returned one clock later. An acknowledge output tells the host when a new phase may start. A program word travels as two bus transfers. Data memory locations reserved for memory-mapped control registers cannot be written from the host.

Top module: `hport_top`

## Requirements
- R1: After reset `h_ack` is 1, `mem_req` is 0, `h_dout` is 0, the held location is 0 and program memory is selected.
- R2: When the synchronised address strobe falls, the port stores `h_din[13:0]` as the location and `h_din[14]` as the memory select (1 = data memory, 0 = program memory), and the next program transfer is an upper-half transfer. `h_din[15]` has no effect.
- R3: When `h_sel` and either `h_rd` or `h_wr` are seen active, `mem_req` goes high after the third rising clock edge counted from the first edge that samples them, and stays high for exactly one cycle. If it is not held low for that access (R7, R9), it carries the held location and memory select.
- R4: `h_ack` is 0 in the cycle of the memory request and returns to 1 two cycles later, together with the read data. A new access is accepted only after the strobes have been seen inactive.
- R5: A data memory write drives `mem_wdata = {8'h00, h_din}` and then steps the location by one.
- R6: A data memory read returns `mem_rdata[15:0]` on `h_dout` and then steps the location by one.
- R7: A program memory write takes two transfers. The first stores `h_din` as bits 23:8 and makes no memory request. The second writes `{stored, h_din[7:0]}`. The location steps only after the second transfer.
- R8: A program memory read takes two transfers of the same location. The first returns bits 23:8 and the second returns `{8'h00, bits 7:0}`. The location steps only after the second transfer.
- R9: A data memory write to a location at or above `CREG_BASE` (default 14'h3FE0) makes no memory request. The transfer still completes and steps the location. Reads there are served normally.
- R10: The location wraps from 14'h3FFF to 14'h0000.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| h_alat | input | 1 | Host address strobe, location captured on its fall |
| h_sel | input | 1 | Host select |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_din | input | 16 | Host bus, location/select or write data |
| h_dout | output | 16 | Read data toward the host |
| h_ack | output | 1 | High when the port can take a new phase |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_dm | output | 1 | Request targets data memory |
| mem_addr | output | 14 | Request location |
| mem_wdata | output | 24 | Write word |
| mem_rdata | input | 24 | Read word, valid the cycle after the request |

## Verification
The checks assume a well-behaved host. It keeps `h_din` steady from the rise of the address strobe until three clocks after its fall. It holds write data and strobes until `h_ack` returns. It never raises the read and write strobes together. It leaves the strobes low for several clocks before the next phase and never moves the address strobe during a transfer. The bench tasks pace every phase with fixed clock counts that cover the synchroniser depth, so random blocks of reads and writes of random length, at random locations and in either memory, stay inside these rules.

// File: rtl/hport_pkg.sv
package hport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_CAP  = 2'd2,
    ST_REL  = 2'd3
  } hp_state_e;

endpackage

// File: rtl/hport_sync.sv
module hport_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/hport_addr.sv
module hport_addr #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          latch_en,
  input  logic [AW-1:0] latch_addr,
  input  logic          latch_dm,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          is_dm
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      is_dm <= 1'b0;
    end else if (latch_en) begin
      addr  <= latch_addr;
      is_dm <= latch_dm;
    end else if (inc) begin
      addr  <= addr + AW'(1);
    end
  end

  // R2
  latch_take_chk: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> (addr == $past(latch_addr)) && (is_dm == $past(latch_dm)));

  // R10
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !latch_en) |=> addr == $past(addr) + AW'(1));

endmodule

// File: rtl/hport_ctrl.sv
module hport_ctrl import hport_pkg::*; #(
  parameter int DW        = 16,
  parameter int AW        = 14,
  parameter int MW        = 24,
  parameter int CREG_BASE = 'h3FE0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_sel,
  input  logic          s_rd,
  input  logic          s_wr,
  input  logic [DW-1:0] bus_in,
  input  logic          latch_ev,
  input  logic [AW-1:0] cur_addr,
  input  logic          cur_dm,
  output logic          inc,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_dm,
  output logic [AW-1:0] mem_addr,
  output logic [MW-1:0] mem_wdata,
  input  logic [MW-1:0] mem_rdata,
  output logic [DW-1:0] dout,
  output logic          ack
);

  localparam int            LOW_W  = MW - DW;
  localparam int            PAD_W  = DW - LOW_W;
  localparam logic [AW-1:0] CREG_A = AW'(CREG_BASE);

  hp_state_e     state;
  logic          op_wr;
  logic          op_dm;
  logic          phase_hi;
  logic [DW-1:0] hold;

  logic act, wr_req, blocked, need_mem;

  always_comb begin
    act      = s_sel & (s_rd | s_wr);
    wr_req   = s_wr & ~s_rd;
    blocked  = cur_dm && (cur_addr >= CREG_A);
    need_mem = !wr_req || (cur_dm ? !blocked : !phase_hi);
  end

  assign inc = (state == ST_CAP) && (op_dm || !phase_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_wr     <= 1'b0;
      op_dm     <= 1'b0;
      phase_hi  <= 1'b1;
      hold      <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_dm    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      dout      <= '0;
      ack       <= 1'b1;
    end else begin
      mem_req <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (act) begin
            state    <= ST_REQ;
            ack      <= 1'b0;
            op_wr    <= wr_req;
            op_dm    <= cur_dm;
            mem_req  <= need_mem;
            mem_we   <= wr_req;
            mem_dm   <= cur_dm;
            mem_addr <= cur_addr;
            if (cur_dm) mem_wdata <= {{LOW_W{1'b0}}, bus_in};
            else        mem_wdata <= {hold, bus_in[LOW_W-1:0]};
            if (wr_req && !cur_dm && phase_hi) hold <= bus_in;
          end
        end
        ST_REQ: state <= ST_CAP;
        ST_CAP: begin
          if (!op_wr) begin
            if (op_dm)         dout <= mem_rdata[DW-1:0];
            else if (phase_hi) dout <= mem_rdata[MW-1:LOW_W];
            else               dout <= {{PAD_W{1'b0}}, mem_rdata[LOW_W-1:0]};
          end
          if (!op_dm) phase_hi <= !phase_hi;
          ack   <= 1'b1;
          state <= ST_REL;
        end
        default: begin
          if (!act) state <= ST_IDLE;
        end
      endcase
      if (latch_ev) phase_hi <= 1'b1;
    end
  end

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R4
  ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !ack);

  // R9
  creg_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_dm) |-> (mem_addr < CREG_A));

  // R7
  pm_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !mem_dm) |-> !phase_hi);

endmodule

// File: rtl/hport_top.sv
module hport_top #(
  parameter int DW          = 16,
  parameter int AW          = 14,
  parameter int MW          = 24,
  parameter int CREG_BASE   = 'h3FE0,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_alat,
  input  logic          h_sel,
  input  logic          h_rd,
  input  logic          h_wr,
  input  logic [15:0]   h_din,
  output logic [15:0]   h_dout,
  output logic          h_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_dm,
  output logic [13:0]   mem_addr,
  output logic [23:0]   mem_wdata,
  input  logic [23:0]   mem_rdata
);

  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_v, syn_v;
  logic             s_alat, s_sel, s_rd, s_wr, s_alat_d;
  logic             latch_ev, inc, cur_dm;
  logic [AW-1:0]    cur_addr;

  assign raw_v = {h_alat, h_sel, h_rd, h_wr};
  assign {s_alat, s_sel, s_rd, s_wr} = syn_v;

  hport_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (raw_v),
    .q   (syn_v)
  );

  always_ff @(posedge clk) begin
    if (rst) s_alat_d <= 1'b0;
    else     s_alat_d <= s_alat;
  end

  assign latch_ev = s_alat_d & ~s_alat;

  hport_addr #(.AW(AW)) addr_i (
    .clk        (clk),
    .rst        (rst),
    .latch_en   (latch_ev),
    .latch_addr (h_din[AW-1:0]),
    .latch_dm   (h_din[AW]),
    .inc        (inc),
    .addr       (cur_addr),
    .is_dm      (cur_dm)
  );

  hport_ctrl #(.DW(DW), .AW(AW), .MW(MW), .CREG_BASE(CREG_BASE)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .s_sel     (s_sel),
    .s_rd      (s_rd),
    .s_wr      (s_wr),
    .bus_in    (h_din),
    .latch_ev  (latch_ev),
    .cur_addr  (cur_addr),
    .cur_dm    (cur_dm),
    .inc       (inc),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_dm    (mem_dm),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .dout      (h_dout),
    .ack       (h_ack)
  );

  // R1
  ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!s_sel && !s_rd && !s_wr && $past(!s_sel && !s_rd && !s_wr) && !mem_req) |=> h_ack);

endmodule

// File: tb/hport_top_tb_top.sv
module hport_top_tb_top;

  localparam logic [13:0] CREG = 14'h3FE0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_alat = 0, h_sel = 0, h_rd = 0, h_wr = 0;
  logic [15:0] h_din = '0;
  logic [15:0] h_dout;
  logic        h_ack, mem_req, mem_we, mem_dm;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata;
  logic [23:0] mem_rdata = '0;

  always #10 clk = ~clk;

  hport_top dut_i (
    .clk(clk), .rst(rst), .h_alat(h_alat), .h_sel(h_sel), .h_rd(h_rd),
    .h_wr(h_wr), .h_din(h_din), .h_dout(h_dout), .h_ack(h_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_dm(mem_dm),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory models
  logic [23:0] dm_mem [int];
  logic [23:0] pm_mem [int];
  int req_cnt = 0;

  always @(posedge clk) begin
    if (mem_req) begin
      req_cnt++;
      if (mem_we) begin
        if (mem_dm) dm_mem[int'(mem_addr)] = mem_wdata;
        else        pm_mem[int'(mem_addr)] = mem_wdata;
      end else if (mem_dm) begin
        mem_rdata <= dm_mem.exists(int'(mem_addr)) ? dm_mem[int'(mem_addr)] : 24'h0;
      end else begin
        mem_rdata <= pm_mem.exists(int'(mem_addr)) ? pm_mem[int'(mem_addr)] : 24'h0;
      end
    end
  end

  // expected model
  logic [23:0] exp_dm [int];
  logic [23:0] exp_pm [int];
  int          cur_addr = 0;
  bit          cur_dm = 0, cur_hi = 1;
  logic [15:0] pm_hold = '0;
  int          n_cmp = 0, n_bad = 0;

  function automatic logic [23:0] exp_get(bit dm, int a);
    if (dm) return exp_dm.exists(a) ? exp_dm[a] : 24'h0;
    return exp_pm.exists(a) ? exp_pm[a] : 24'h0;
  endfunction

  function automatic logic [15:0] exp_read(bit dm, bit hi, int a);
    logic [23:0] w;
    w = exp_get(dm, a);
    if (dm) return w[15:0];
    if (hi) return w[23:8];
    return {8'h00, w[7:0]};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic latch(int a, bit dm, bit b15);
    @(negedge clk);
    h_din  = {b15, dm, 14'(a)};
    h_alat = 1'b1;
    repeat (3) @(negedge clk);
    h_alat = 1'b0;
    repeat (4) @(negedge clk);
    cur_addr = a & 16'h3FFF;
    cur_dm   = dm;
    cur_hi   = 1'b1;
  endtask

  task automatic xfer(bit wr, logic [15:0] data);
    bit          blocked, exp_req;
    logic [23:0] exp_wd;
    logic [15:0] exp_rd;
    int          n;
    blocked = cur_dm && (14'(cur_addr) >= CREG);
    exp_req = !wr || (cur_dm ? !blocked : !cur_hi);
    exp_wd  = cur_dm ? {8'h00, data} : {pm_hold, data[7:0]};
    exp_rd  = exp_read(cur_dm, cur_hi, cur_addr);
    @(negedge clk);
    h_din = data;
    h_sel = 1'b1;
    if (wr) h_wr = 1'b1; else h_rd = 1'b1;
    repeat (3) @(negedge clk);
    check(mem_req == exp_req, "R3", "request timing", 32'(mem_req), 32'(exp_req));
    check(h_ack == 1'b0, "R4", "ack low during request", 32'(h_ack), 32'h0);
    if (exp_req) begin
      check(mem_addr == 14'(cur_addr) && mem_dm == cur_dm, "R3", "request location",
            {17'h0, mem_dm, mem_addr}, {17'h0, cur_dm, 14'(cur_addr)});
      if (wr) check(mem_wdata == exp_wd, cur_dm ? "R5" : "R7", "write word",
                    32'(mem_wdata), 32'(exp_wd));
    end
    n = 0;
    while (!h_ack && n < 10) begin
      @(negedge clk);
      n++;
    end
    check(h_ack == 1'b1 && n == 2, "R4", "ack return cycles", 32'(n), 32'd2);
    if (!wr) check(h_dout == exp_rd, cur_dm ? "R6" : "R8", "read data",
                   32'(h_dout), 32'(exp_rd));
    h_sel = 1'b0; h_wr = 1'b0; h_rd = 1'b0;
    repeat (4) @(negedge clk);
    if (wr) begin
      if (cur_dm) begin
        if (!blocked) exp_dm[cur_addr] = {8'h00, data};
      end else if (cur_hi) begin
        pm_hold = data;
      end else begin
        exp_pm[cur_addr] = {pm_hold, data[7:0]};
      end
    end
    if (cur_dm) cur_addr = (cur_addr + 1) & 16'h3FFF;
    else if (cur_hi) cur_hi = 1'b0;
    else begin
      cur_hi   = 1'b1;
      cur_addr = (cur_addr + 1) & 16'h3FFF;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R4 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int c0;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(h_ack == 1'b1, "R1", "ack after reset", 32'(h_ack), 32'h1);
    check(mem_req == 1'b0, "R1", "no request after reset", 32'(mem_req), 32'h0);
    check(h_dout == 16'h0, "R1", "dout after reset", 32'(h_dout), 32'h0);
    // R1: location 0 in program memory without any latch
    cur_addr = 0; cur_dm = 0; cur_hi = 1;
    xfer(1'b0, 16'h0);

    // R5 R6 data memory write/read with stepping; R2 bit 15 ignored
    latch(16'h0010, 1'b1, 1'b1);
    xfer(1'b1, 16'h1234);
    xfer(1'b1, 16'hBEEF);
    latch(16'h0010, 1'b1, 1'b0);
    xfer(1'b0, 16'h0);
    xfer(1'b0, 16'h0);
    check(exp_get(1'b1, 16'h0011) == 24'h00BEEF, "R5", "model step", 32'(exp_get(1'b1, 16'h0011)), 32'h00BEEF);

    // R7 program write pair; R8 program read pair
    latch(16'h0020, 1'b0, 1'b0);
    c0 = req_cnt;
    xfer(1'b1, 16'hABCD);
    check(req_cnt == c0, "R7", "no request on upper half", 32'(req_cnt - c0), 32'h0);
    xfer(1'b1, 16'h0055);
    latch(16'h0020, 1'b0, 1'b0);
    xfer(1'b0, 16'h0);
    xfer(1'b0, 16'h0);
    // R2 memory select: same location in data memory
    latch(16'h0020, 1'b1, 1'b0);
    xfer(1'b0, 16'h0);

    // R9 control-register region
    latch(16'h3FDF, 1'b1, 1'b0);
    c0 = req_cnt;
    xfer(1'b1, 16'h1111);
    xfer(1'b1, 16'h2222);
    check(req_cnt - c0 == 1, "R9", "blocked write requests", 32'(req_cnt - c0), 32'h1);
    latch(16'h3FDF, 1'b1, 1'b0);
    xfer(1'b0, 16'h0);
    xfer(1'b0, 16'h0);

    // R10 wrap in program memory
    latch(16'h3FFF, 1'b0, 1'b0);
    xfer(1'b1, 16'h0102);
    xfer(1'b1, 16'h0003);
    xfer(1'b1, 16'h0405);
    xfer(1'b1, 16'h0006);
    latch(16'h0000, 1'b0, 1'b0);
    xfer(1'b0, 16'h0);
    xfer(1'b0, 16'h0);
    check(exp_get(1'b0, 0) == 24'h040506, "R10", "wrapped word", 32'(exp_get(1'b0, 0)), 32'h040506);

    // random blocks
    for (int b = 0; b < 40; b++) begin
      bit dm, wr;
      int a, len;
      dm  = 1'($urandom % 2);
      wr  = 1'($urandom % 2);
      len = 1 + int'($urandom % 4);
      if ($urandom % 4 == 0) a = 16'h3FDC + int'($urandom % 8);
      else                   a = int'($urandom % 64);
      latch(a, dm, 1'($urandom % 2));
      for (int i = 0; i < len; i++) begin
        if (dm) xfer(wr, 16'($urandom));
        else begin
          xfer(wr, 16'($urandom));
          xfer(wr, 16'($urandom));
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule